// File: doc/BRIEF.md
# Accumulator Processor Core with Single Internal Bus

This block is a compact accumulator machine: 12-bit data words, an 8-bit word address space, and sixteen opcode slots of which thirteen are defined. Six registers share one internal bus. These are the memory address latch, the memory data latch, the program counter, the stack pointer, the instruction register and the accumulator. Every register has its own load enable from the bus, and only one register drives the bus at a time.

A sequencer made of one fetch/execute state bit and a two-bit phase count steps through the register transfers. Every instruction uses exactly four fetch cycles and then four execute cycles. The core drives a synchronous single-port memory. The memory address always comes from the address latch and the write data always comes from the data latch. Read data arrives one clock after the address. Three status outputs tell whether the core is fetching, executing or halted.

An instruction word holds the opcode in bits 11:8 and an 8-bit address operand in bits 7:0. The stack grows downward from the top of the address space. A subroutine call stores the return address in memory at the stack pointer.

Top module: `cpu_acc`

## Requirements
- R1: Reset clears the program counter and the accumulator and sets the stack pointer to 0xFF. The first instruction is fetched from address 0 and no memory write occurs while the core is in reset.
- R2: An instruction word is opcode[11:8] plus operand[7:0]. Each instruction takes 4 cycles with `fetch_o` high, followed by 4 cycles with `exec_o` high.
- R3: `mem_addr` comes from the address latch and `mem_wdata` from the data latch. Read data is expected one cycle after the address. A write is a single-cycle `mem_we` pulse, and the address is held steady during that pulse.
- R4: READ (0001) loads the accumulator from memory at the operand address. WRITE (0010) stores the accumulator to memory at the operand address.
- R5: ADD (0000), AND (0100) and OR (0101) combine the accumulator with the memory word at the operand address. ADD wraps modulo 2^12.
- R6: NEG (0011) replaces the accumulator with its two's complement. RSHIFT (1001) and LSHIFT (1010) shift it by one bit and fill with zero.
- R7: JMP (1100) loads the program counter from the operand. JNZ (0110) does the same only when the accumulator is nonzero; otherwise execution continues at the next word.
- R8: JSR (0111) first decrements the stack pointer, then stores the address of the following instruction at that location, then jumps. RET (1000) loads the program counter from memory at the stack pointer and increments the stack pointer. Calls nest, and the stack pointer moves by at most one per cycle.
- R9: HALT (1011) raises `halt_o` one cycle after its first execute cycle. `halt_o` then stays high until reset, and no memory write happens while halted.
- R10: Opcodes 1101, 1110 and 1111 change no register except the program counter, which advances to the next word.
- R11: Exactly one of `fetch_o`, `exec_o` and `halt_o` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory address (address latch) |
| mem_wdata | output | 12 | Memory write data (data latch) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 12 | Registered memory read data |
| halt_o | output | 1 | Core halted |
| fetch_o | output | 1 | Fetch phase active |
| exec_o | output | 1 | Execute phase active |

## Verification
Nested calls are exercised with a second call made after both returns, so that the stored return addresses and their slots are checked. A stack pointer that failed to decrement before storing, or failed to increment on return, would write to a different slot on the second call. It would also return to the wrong word, which makes later writes disappear or appear out of order. JNZ is exercised both with a zero and with a nonzero accumulator, and branches that land on WRITE instructions expose a wrong decision as an extra or missing write. ADD overflow, shifts that push a one out of the word, a reused accumulator after a reset, an undefined opcode, and the exact cycle on which halt rises all target off-by-one and wrap faults. Each of these would show up as a wrong data value or a shifted halt cycle.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OPC_ADD   = 4'h0;
    localparam logic [OPW-1:0] OPC_READ  = 4'h1;
    localparam logic [OPW-1:0] OPC_WRITE = 4'h2;
    localparam logic [OPW-1:0] OPC_NEG   = 4'h3;
    localparam logic [OPW-1:0] OPC_AND   = 4'h4;
    localparam logic [OPW-1:0] OPC_OR    = 4'h5;
    localparam logic [OPW-1:0] OPC_JNZ   = 4'h6;
    localparam logic [OPW-1:0] OPC_JSR   = 4'h7;
    localparam logic [OPW-1:0] OPC_RET   = 4'h8;
    localparam logic [OPW-1:0] OPC_SHR   = 4'h9;
    localparam logic [OPW-1:0] OPC_SHL   = 4'hA;
    localparam logic [OPW-1:0] OPC_HALT  = 4'hB;
    localparam logic [OPW-1:0] OPC_JMP   = 4'hC;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_PC, SRC_SP, SRC_IR, SRC_MBR, SRC_AC
    } bus_src_e;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_ADD, ALU_AND, ALU_OR, ALU_NEG, ALU_SHR, ALU_SHL
    } alu_op_e;

    typedef struct packed {
        bus_src_e src;
        logic     mar_ld;
        logic     mbr_ld_bus;
        logic     mbr_ld_mem;
        logic     pc_ld;
        logic     pc_inc;
        logic     sp_inc;
        logic     sp_dec;
        logic     ir_ld;
        logic     ac_ld;
        alu_op_e  alu;
        logic     mem_we;
    } ctrl_t;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = 12
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NEG: y = DW'(0) - a;
            ALU_SHR: y = a >> 1;
            ALU_SHL: y = a << 1;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    input  logic           ac_nz,
    output ctrl_t          ctl,
    output logic           halted,
    output logic           fetching,
    output logic           executing
);

    typedef struct packed {
        logic       exec;
        logic [1:0] phase;
        logic       halted;
    } seq_t;

    seq_t seq_d, seq_q;

    // operand fetch shared by ADD/AND/OR/READ and by RET (address source differs)
    function automatic ctrl_t load_operand(input logic [1:0] ph, input bus_src_e asrc);
        ctrl_t c;
        c = '0;
        case (ph)
            2'd0: begin c.src = asrc; c.mar_ld = 1'b1; end
            2'd2: c.mbr_ld_mem = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

    always_comb begin
        seq_d = seq_q;
        ctl   = '0;
        if (!seq_q.halted) begin
            seq_d.phase = seq_q.phase + 2'd1;
            if (seq_q.phase == 2'd3) seq_d.exec = ~seq_q.exec;

            if (!seq_q.exec) begin
                case (seq_q.phase)
                    2'd0: begin ctl.src = SRC_PC; ctl.mar_ld = 1'b1; end
                    2'd1: ctl.pc_inc = 1'b1;
                    2'd2: ctl.mbr_ld_mem = 1'b1;
                    default: begin ctl.src = SRC_MBR; ctl.ir_ld = 1'b1; end
                endcase
            end else begin
                case (opcode)
                    OPC_ADD, OPC_AND, OPC_OR, OPC_READ: begin
                        ctl = load_operand(seq_q.phase, SRC_IR);
                        if (seq_q.phase == 2'd3) begin
                            ctl.src    = SRC_MBR;
                            ctl.ac_ld  = 1'b1;
                            ctl.alu    = (opcode == OPC_ADD) ? ALU_ADD :
                                         (opcode == OPC_AND) ? ALU_AND :
                                         (opcode == OPC_OR)  ? ALU_OR  : ALU_PASS;
                        end
                    end
                    OPC_WRITE: begin
                        case (seq_q.phase)
                            2'd0: begin ctl.src = SRC_IR; ctl.mar_ld = 1'b1; end
                            2'd1: begin ctl.src = SRC_AC; ctl.mbr_ld_bus = 1'b1; end
                            2'd2: ctl.mem_we = 1'b1;
                            default: ;
                        endcase
                    end
                    OPC_NEG, OPC_SHR, OPC_SHL: begin
                        if (seq_q.phase == 2'd0) begin
                            ctl.ac_ld = 1'b1;
                            ctl.alu   = (opcode == OPC_NEG) ? ALU_NEG :
                                        (opcode == OPC_SHR) ? ALU_SHR : ALU_SHL;
                        end
                    end
                    OPC_JMP: begin
                        if (seq_q.phase == 2'd0) begin
                            ctl.src = SRC_IR; ctl.pc_ld = 1'b1;
                        end
                    end
                    OPC_JNZ: begin
                        if (seq_q.phase == 2'd0 && ac_nz) begin
                            ctl.src = SRC_IR; ctl.pc_ld = 1'b1;
                        end
                    end
                    OPC_JSR: begin
                        case (seq_q.phase)
                            2'd0: ctl.sp_dec = 1'b1;
                            2'd1: begin ctl.src = SRC_SP; ctl.mar_ld = 1'b1; end
                            2'd2: begin ctl.src = SRC_PC; ctl.mbr_ld_bus = 1'b1; end
                            default: begin
                                ctl.mem_we = 1'b1;
                                ctl.src    = SRC_IR;
                                ctl.pc_ld  = 1'b1;
                            end
                        endcase
                    end
                    OPC_RET: begin
                        ctl = load_operand(seq_q.phase, SRC_SP);
                        if (seq_q.phase == 2'd3) begin
                            ctl.src    = SRC_MBR;
                            ctl.pc_ld  = 1'b1;
                            ctl.sp_inc = 1'b1;
                        end
                    end
                    OPC_HALT: begin
                        seq_d.halted = 1'b1;
                        seq_d.phase  = seq_q.phase;
                        seq_d.exec   = seq_q.exec;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign halted    = seq_q.halted;
    assign fetching  = !seq_q.halted && !seq_q.exec;
    assign executing = !seq_q.halted && seq_q.exec;

    // R2: four phases per half, then the half flips
    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.halted && seq_q.phase == 2'd3) |=>
            (seq_q.phase == 2'd0 && seq_q.exec != $past(seq_q.exec)))
        else $error("phase sequencing broken");

    // R9: halt is sticky
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.halted |=> seq_q.halted)
        else $error("halt released without reset");

endmodule

// File: rtl/cpu_dp.sv
module cpu_dp
    import cpu_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic          ac_nz
);

    localparam logic [AW-1:0] SP_TOP = {AW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [DW-1:0] ir;
        logic [DW-1:0] ac;
    } regs_t;

    regs_t         r_d, r_q;
    logic [DW-1:0] bus;
    logic [DW-1:0] alu_y;

    always_comb begin
        case (ctl.src)
            SRC_PC:  bus = DW'(r_q.pc);
            SRC_SP:  bus = DW'(r_q.sp);
            SRC_IR:  bus = DW'(r_q.ir[AW-1:0]);
            SRC_MBR: bus = r_q.mbr;
            SRC_AC:  bus = r_q.ac;
            default: bus = '0;
        endcase
    end

    cpu_alu #(.DW(DW)) u_alu (
        .op (ctl.alu),
        .a  (r_q.ac),
        .b  (bus),
        .y  (alu_y)
    );

    always_comb begin
        r_d = r_q;
        if (ctl.mar_ld)     r_d.mar = bus[AW-1:0];
        if (ctl.mbr_ld_bus) r_d.mbr = bus;
        if (ctl.mbr_ld_mem) r_d.mbr = mem_rdata;
        if (ctl.pc_ld)      r_d.pc  = bus[AW-1:0];
        else if (ctl.pc_inc) r_d.pc = r_q.pc + AW'(1);
        if (ctl.sp_dec)     r_d.sp  = r_q.sp - AW'(1);
        else if (ctl.sp_inc) r_d.sp = r_q.sp + AW'(1);
        if (ctl.ir_ld)      r_d.ir  = bus;
        if (ctl.ac_ld)      r_d.ac  = alu_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.sp <= SP_TOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign mar   = r_q.mar;
    assign mbr   = r_q.mbr;
    assign ir    = r_q.ir;
    assign ac_nz = |r_q.ac;

    // R8: stack pointer moves by at most one per cycle
    p_sp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (r_q.sp == $past(r_q.sp) ||
                  r_q.sp == AW'($past(r_q.sp) + AW'(1)) ||
                  r_q.sp == AW'($past(r_q.sp) - AW'(1))))
        else $error("stack pointer jumped");

    // R3: address already settled when a write strobe fires
    p_we_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_we |-> $stable(r_q.mar))
        else $error("address moved under write");

endmodule

// File: rtl/cpu_acc.sv
module cpu_acc
    import cpu_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halt_o,
    output logic          fetch_o,
    output logic          exec_o
);

    ctrl_t         ctl;
    logic [DW-1:0] ir;
    logic          ac_nz;

    cpu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (ir[DW-1 -: OPW]),
        .ac_nz     (ac_nz),
        .ctl       (ctl),
        .halted    (halt_o),
        .fetching  (fetch_o),
        .executing (exec_o)
    );

    cpu_dp #(.DW(DW), .AW(AW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mem_addr),
        .mbr       (mem_wdata),
        .ir        (ir),
        .ac_nz     (ac_nz)
    );

    assign mem_we = ctl.mem_we;

    // R11: exactly one status output active
    p_one_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({halt_o, fetch_o, exec_o}) == 1)
        else $error("status outputs not exclusive");

    // R3: write strobe lasts one cycle
    p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we)
        else $error("write strobe too long");

    // R9: no writes once halted
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !mem_we)
        else $error("write while halted");

endmodule

// File: tb/sim_cpu_acc.sv
module sim_cpu_acc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [11:0] mem_wdata;
    logic        mem_we;
    logic [11:0] mem_rdata;
    logic        halt_o, fetch_o, exec_o;

    logic        ld_we = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [11:0] ld_data = '0;
    logic [11:0] mem [256];

    int checks = 0;
    int errors = 0;

    logic [7:0]  exp_a[$];
    logic [11:0] exp_d[$];
    string       exp_t[$];

    always #5 clk = ~clk;

    cpu_acc u0 (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata),
        .halt_o(halt_o), .fetch_o(fetch_o), .exec_o(exec_o)
    );

    // synchronous single-port memory model
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    // monitor: every write strobe pops one expected item
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_a.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected write: actual %02h<=%03h expected none",
                         mem_addr, mem_wdata);
            end else begin
                automatic logic [7:0]  ea = exp_a.pop_front();
                automatic logic [11:0] ed = exp_d.pop_front();
                automatic string       et = exp_t.pop_front();
                if (mem_addr !== ea || mem_wdata !== ed) begin
                    errors++;
                    $display("FAIL %s write: actual %02h<=%03h expected %02h<=%03h",
                             et, mem_addr, mem_wdata, ea, ed);
                end
            end
        end
    end

    function automatic logic [11:0] ins(input logic [3:0] op, input logic [7:0] a);
        return {op, a};
    endfunction

    task automatic expect_wr(input logic [7:0] a, input logic [11:0] d, input string t);
        exp_a.push_back(a);
        exp_d.push_back(d);
        exp_t.push_back(t);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [11:0] d);
        ld_addr = a; ld_data = d; ld_we = 1'b1;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic wipe();
        rst_n = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run(input int halt_cycle);
        int n = 0;
        @(negedge clk);
        check(mem_we === 1'b0, "R1 no write in reset", mem_we, 0);
        rst_n = 1'b1;
        while (!halt_o && n < 3000) begin
            if (n == 0) check(fetch_o === 1'b1 && halt_o === 1'b0, "R1 fetch after reset", fetch_o, 1);
            if (n == 2) check(mem_addr === 8'h00, "R1 first fetch address", mem_addr, 0);
            if (n == 4) check(exec_o === 1'b1 && fetch_o === 1'b0, "R2 execute after four cycles", exec_o, 1);
            @(negedge clk);
            n++;
        end
        check(n == halt_cycle, "R9 halt cycle", n, halt_cycle);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k == 39) check(halt_o === 1'b1 && fetch_o === 1'b0 && exec_o === 1'b0,
                               "R9 halt held", halt_o, 1);
        end
        check(exp_a.size() == 0, "R3 all writes seen", exp_a.size(), 0);
        exp_a.delete(); exp_d.delete(); exp_t.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);

        // ---- program A: arithmetic and logic
        wipe();
        put(8'h40, 12'h123); put(8'h41, 12'h0F0); put(8'h42, 12'hFFF);
        put(8'h00, ins(4'h1, 8'h40)); put(8'h01, ins(4'h0, 8'h41));
        put(8'h02, ins(4'h2, 8'h80)); put(8'h03, ins(4'h4, 8'h41));
        put(8'h04, ins(4'h2, 8'h81)); put(8'h05, ins(4'h5, 8'h40));
        put(8'h06, ins(4'h2, 8'h82)); put(8'h07, ins(4'h3, 8'h00));
        put(8'h08, ins(4'h2, 8'h83)); put(8'h09, ins(4'h9, 8'h00));
        put(8'h0A, ins(4'h2, 8'h84)); put(8'h0B, ins(4'hA, 8'h00));
        put(8'h0C, ins(4'hA, 8'h00)); put(8'h0D, ins(4'h2, 8'h85));
        put(8'h0E, ins(4'h1, 8'h42)); put(8'h0F, ins(4'h0, 8'h41));
        put(8'h10, ins(4'h2, 8'h86)); put(8'h11, ins(4'hB, 8'h00));
        expect_wr(8'h80, 12'h213, "R4 R5 read+add");
        expect_wr(8'h81, 12'h010, "R5 and");
        expect_wr(8'h82, 12'h133, "R5 or");
        expect_wr(8'h83, 12'hECD, "R6 neg");
        expect_wr(8'h84, 12'h766, "R6 rshift");
        expect_wr(8'h85, 12'hD98, "R6 lshift");
        expect_wr(8'h86, 12'h0EF, "R5 add wrap");
        run(141);

        // ---- program B: branches, calls, undefined opcode
        wipe();
        put(8'h40, 12'h000); put(8'h41, 12'h005);
        put(8'h00, ins(4'h1, 8'h40)); put(8'h01, ins(4'h6, 8'h10));
        put(8'h02, ins(4'h2, 8'h80)); put(8'h03, ins(4'h1, 8'h41));
        put(8'h04, ins(4'h6, 8'h08)); put(8'h05, ins(4'h2, 8'h81));
        put(8'h06, ins(4'hB, 8'h00)); put(8'h08, ins(4'hC, 8'h0C));
        put(8'h09, ins(4'h2, 8'h82)); put(8'h0A, ins(4'hB, 8'h00));
        put(8'h0C, ins(4'h7, 8'h20)); put(8'h0D, ins(4'h2, 8'h83));
        put(8'h0E, ins(4'hD, 8'hFF)); put(8'h0F, ins(4'h2, 8'h84));
        put(8'h10, ins(4'h7, 8'h38)); put(8'h11, ins(4'hB, 8'h00));
        put(8'h20, ins(4'h0, 8'h41)); put(8'h21, ins(4'h7, 8'h30));
        put(8'h22, ins(4'h2, 8'h85)); put(8'h23, ins(4'h8, 8'h00));
        put(8'h30, ins(4'h2, 8'h86)); put(8'h31, ins(4'h8, 8'h00));
        put(8'h38, ins(4'h8, 8'h00));
        expect_wr(8'h80, 12'h000, "R7 jnz not taken, R1 ac cleared");
        expect_wr(8'hFE, 12'h00D, "R8 R1 first push");
        expect_wr(8'hFD, 12'h022, "R8 nested push");
        expect_wr(8'h86, 12'h00A, "R8 inner body");
        expect_wr(8'h85, 12'h00A, "R8 return to outer");
        expect_wr(8'h83, 12'h00A, "R8 return to main");
        expect_wr(8'h84, 12'h00A, "R10 undefined opcode");
        expect_wr(8'hFE, 12'h011, "R8 stack restored");
        run(149);

        // ---- program C: accumulator cleared by reset after program B
        wipe();
        put(8'h00, ins(4'h2, 8'h90)); put(8'h01, ins(4'hB, 8'h00));
        expect_wr(8'h90, 12'h000, "R1 accumulator reset");
        run(13);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule